// File: doc/BRIEF.md
# Write-Through Register File

This block is the architectural integer register file of an in-order pipeline: a parameterised array of general registers with one write port and several read ports (two by default). The write port is driven by the write-back stage. The read ports are addressed by the decode stage and return data in the same cycle, through combinational paths. Entry zero is not storage. It is a constant zero, and any write aimed at it is dropped.

A write presented on the write port is committed at the rising clock edge. The same data is also returned, in that same cycle, to any read port that addresses the register being written. A consumer that decodes while its producer is in write-back therefore sees the new value without any forwarding path outside the file. That is the case of a producer three instructions ahead. Producers four or more instructions ahead are served by ordinary array reads. Each read port compares addresses on its own, so every port can take the write data in the same cycle.

A parameter selects the read path. The write-through variant is the default. The plain variant returns only the stored contents, for pipelines that resolve the third-distance case elsewhere.

Top module: `regfile_wt`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every register is cleared to zero. After release, every address reads zero until that register is written.
- R2: A value written with the write enable high to a nonzero address is returned by every read port that addresses that register in any later cycle, until the register is overwritten.
- R3: A read port addressing register 0 always returns all zeros.
- R4: A write addressed to register 0 has no effect. In the same cycle and in later cycles, register 0 still reads zero and every other register keeps its contents.
- R5: In a cycle where the write enable is high and the write address is nonzero, a read port whose address equals the write address returns the write data in that same cycle.
- R6: Read ports bypass independently: when every read port addresses the register being written, all of them return the write data in that cycle.
- R7: With the write enable low, the write address and write data are ignored. No register changes, and no read port returns the write data.
- R8: A read port whose address differs from the write address returns the stored contents of its own register, whatever write happens in the same cycle.
- R9: When the same register is written in consecutive cycles, the later write is returned: in its own cycle through the bypass, and afterwards from storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| wr_en | input | 1 | Write enable from write-back |
| wr_addr | input | ADDR_W | Register index being written |
| wr_data | input | DATA_W | Data being written |
| rd_addr | input | RD_PORTS*ADDR_W | Read indices; port p occupies bits [p*ADDR_W +: ADDR_W] |
| rd_data | output | RD_PORTS*DATA_W | Read results; port p occupies bits [p*DATA_W +: DATA_W] |

## Verification
The properties assume that every address is below the register count and that the write enable never carries an unknown value. They also assume that inputs settle between rising edges, because read data is combinational and is sampled at the edge. The stimulus changes every input only on the falling edge and uses the default count of 32, a power of two, so all address codes are legal. It keeps the write enable low for the whole reset interval, including the reset issued mid-run. The persistence and hold properties look only one cycle back and are gated until one full cycle has passed since reset.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

   // Source chosen by a read port for its output word.
   typedef enum logic [1:0] {
      RSRC_ZERO  = 2'd0,
      RSRC_ARRAY = 2'd1,
      RSRC_WRITE = 2'd2
   } rsrc_e;

endpackage

// File: rtl/rfb_wdec.sv
// Write-address decoder: one enable per stored entry (entry 0 has none).
module rfb_wdec #(
   parameter int NUM_REGS = 32,
   parameter int ADDR_W   = 5
) (
   input  logic                  we,
   input  logic [ADDR_W-1:0]     waddr,
   output logic [NUM_REGS-1:1]   sel
);

   for (genvar i = 1; i < NUM_REGS; i++) begin : g_sel
      assign sel[i] = we && (waddr == ADDR_W'(i));
   end

endmodule

// File: rtl/rfb_store.sv
// Storage array: entry 0 is a constant, the others are reset-cleared flops.
module rfb_store #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_REGS-1:1]          sel,
   input  logic [DATA_W-1:0]            wdata,
   output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

   assign regs_flat[DATA_W-1:0] = '0;

   for (genvar i = 1; i < NUM_REGS; i++) begin : g_entry
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (sel[i]) begin
            q <= wdata;
         end
      end

      assign regs_flat[i*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/rfb_rport.sv
// One read port: array mux plus optional same-cycle write-through.
module rfb_rport
   import rfb_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 32,
   parameter int ADDR_W    = 5,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [ADDR_W-1:0]            raddr,
   input  logic [NUM_REGS*DATA_W-1:0]   regs_flat,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            waddr,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            rdata
);

   logic              hit;
   logic              is_zero;
   logic [DATA_W-1:0] stored;
   rsrc_e             src;

   assign is_zero = (raddr == '0);

   if (BYPASS_EN) begin : g_bypass
      assign hit = we && (waddr != '0) && (waddr == raddr);
   end else begin : g_plain
      assign hit = 1'b0;
   end

   always_comb begin
      stored = '0;
      for (int i = 1; i < NUM_REGS; i++) begin
         if (raddr == ADDR_W'(i)) begin
            stored = regs_flat[i*DATA_W +: DATA_W];
         end
      end
   end

   always_comb begin
      if (is_zero) begin
         src = RSRC_ZERO;
      end else if (hit) begin
         src = RSRC_WRITE;
      end else begin
         src = RSRC_ARRAY;
      end
   end

   always_comb begin
      unique case (src)
         RSRC_ZERO:  rdata = '0;
         RSRC_WRITE: rdata = wdata;
         default:    rdata = stored;
      endcase
   end

endmodule

// File: rtl/regfile_wt.sv
// Multi-port register file with write-through read bypass and constant entry 0.
module regfile_wt #(
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 32,
   parameter int ADDR_W    = $clog2(NUM_REGS),
   parameter int RD_PORTS  = 2,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [RD_PORTS*ADDR_W-1:0]   rd_addr,
   output logic [RD_PORTS*DATA_W-1:0]   rd_data
);

   localparam int STORE_W = NUM_REGS * DATA_W;

   // Elaboration-time parameter checks
   if (DATA_W < 1) begin : g_chk_data
      $error("regfile_wt: DATA_W must be at least 1");
   end
   if (NUM_REGS < 2) begin : g_chk_regs
      $error("regfile_wt: NUM_REGS must be at least 2");
   end
   if ((2 ** ADDR_W) < NUM_REGS) begin : g_chk_addr
      $error("regfile_wt: ADDR_W too narrow for NUM_REGS");
   end
   if (RD_PORTS < 1) begin : g_chk_ports
      $error("regfile_wt: RD_PORTS must be at least 1");
   end

   logic [NUM_REGS-1:1] wsel;
   logic [STORE_W-1:0]  regs_flat;

   rfb_wdec #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W)
   ) wdec_i (
      .we    (wr_en),
      .waddr (wr_addr),
      .sel   (wsel)
   );

   rfb_store #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (wsel),
      .wdata     (wr_data),
      .regs_flat (regs_flat)
   );

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rport
      rfb_rport #(
         .DATA_W    (DATA_W),
         .NUM_REGS  (NUM_REGS),
         .ADDR_W    (ADDR_W),
         .BYPASS_EN (BYPASS_EN)
      ) rport_i (
         .raddr     (rd_addr[p*ADDR_W +: ADDR_W]),
         .regs_flat (regs_flat),
         .we        (wr_en),
         .waddr     (wr_addr),
         .wdata     (wr_data),
         .rdata     (rd_data[p*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/regfile_wt_chk.sv
// Property checker, attached to every regfile_wt instance.
module regfile_wt_chk #(
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 32,
   parameter int ADDR_W    = 5,
   parameter int RD_PORTS  = 2,
   parameter bit BYPASS_EN = 1'b1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_en,
   input logic [ADDR_W-1:0]            wr_addr,
   input logic [DATA_W-1:0]            wr_data,
   input logic [RD_PORTS*ADDR_W-1:0]   rd_addr,
   input logic [RD_PORTS*DATA_W-1:0]   rd_data
);

   // fresh: first edge after reset release; armed: at least one edge seen since
   logic fresh;
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh <= 1'b1;
         armed <= 1'b0;
      end else begin
         fresh <= 1'b0;
         armed <= 1'b1;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      logic              wr_same;

      assign a       = rd_addr[p*ADDR_W +: ADDR_W];
      assign d       = rd_data[p*DATA_W +: DATA_W];
      assign wr_same = wr_en && (wr_addr == a);

      assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (fresh && !wr_same) |-> (d == '0));

      assert_x0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (a == '0) |-> (d == '0));

      if (BYPASS_EN) begin : g_bp
         assert_same_cycle_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_same && (a != '0)) |-> (d == wr_data));
      end

      assert_write_persists_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(wr_en) && ($past(wr_addr) != '0) && (a == $past(wr_addr)) && !wr_same)
         |-> (d == $past(wr_data)));

      assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && !$past(wr_en) && (a == $past(a)) && !wr_same)
         |-> (d == $past(d)));
   end

endmodule

bind regfile_wt regfile_wt_chk #(
   .DATA_W    (DATA_W),
   .NUM_REGS  (NUM_REGS),
   .ADDR_W    (ADDR_W),
   .RD_PORTS  (RD_PORTS),
   .BYPASS_EN (BYPASS_EN)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rd_addr (rd_addr),
   .rd_data (rd_data)
);

// File: tb/regfile_wt_tb_top.sv
module regfile_wt_tb_top;

   localparam int DW = 32;
   localparam int NR = 32;
   localparam int AW = 5;
   localparam int NP = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [DW-1:0]     wr_data = '0;
   logic [NP*AW-1:0]  rd_addr = '0;
   logic [NP*DW-1:0]  rd_data;

   logic [DW-1:0]     model [NR];
   int                n_tests = 0;
   int                n_fail  = 0;
   bit                done    = 1'b0;

   always #2 clk = ~clk;   // 4 ns period

   regfile_wt dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   function automatic logic [DW-1:0] pat(input int idx, input int k);
      return (DW'(idx) * 32'h0100_0193) ^ (DW'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
   endfunction

   task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                        input string req, input int port);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s port%0d: got %h expected %h", req, port, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, check before the rising edge.
   task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                       input string t0, input string t1);
      logic [DW-1:0] e0;
      logic [DW-1:0] e1;
      @(negedge clk);
      wr_en   = we;
      wr_addr = wa;
      wr_data = wd;
      rd_addr = {a1, a0};
      #1;
      e0 = (a0 == 0) ? '0 : ((we && wa == a0) ? wd : model[a0]);
      e1 = (a1 == 0) ? '0 : ((we && wa == a1) ? wd : model[a1]);
      check(rd_data[DW-1:0],    e0, t0, 0);
      check(rd_data[2*DW-1:DW], e1, t1, 1);
      if (we && wa != 0) model[wa] = wd;
   endtask

   task automatic do_reset();
      @(negedge clk);
      wr_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NR; i++) model[i] = '0;
   endtask

   initial begin
      for (int i = 0; i < NR; i++) model[i] = '0;
      do_reset();

      // R1: every register reads zero after reset, both ports
      for (int i = 0; i < NR; i++) step(1'b0, '0, '0, AW'(i), AW'(NR-1-i), "R1", "R1");

      // R5 on port 0, R8 on port 1 (unrelated address) for every nonzero register
      for (int i = 1; i < NR; i++)
         step(1'b1, AW'(i), pat(i, 1), AW'(i), AW'((i + 9) % NR), "R5", "R8");

      // R2: stored values readable later; R7: disabled write with live address
      for (int i = 0; i < NR; i++)
         step(1'b0, AW'(i), ~pat(i, 1), AW'(i), AW'(NR-1-i), "R2", "R7");

      // R4: writes to register 0 dropped, other registers intact
      for (int k = 0; k < 4; k++)
         step(1'b1, '0, pat(0, k + 5) | 32'h1, '0, AW'(k + 1), "R4", "R4");
      for (int i = 0; i < NR; i++) step(1'b0, '0, '0, '0, AW'(i), "R3", "R4");

      // R6: both ports bypass the same register in one cycle
      for (int i = 1; i < NR; i++) step(1'b1, AW'(i), pat(i, 2), AW'(i), AW'(i), "R6", "R6");

      // R7: disabled write to a read register, then hold
      step(1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd5, "R7", "R7");
      step(1'b0, '0,   '0,           5'd5, 5'd5, "R7", "R7");

      // R9: consecutive writes to one register
      step(1'b1, 5'd12, pat(12, 7), 5'd12, 5'd3,  "R9", "R8");
      step(1'b1, 5'd12, pat(12, 8), 5'd12, 5'd12, "R9", "R9");
      step(1'b0, '0,    '0,         5'd12, 5'd12, "R9", "R9");

      // Distance sequence: write, then ordinary reads afterwards (R5 then R2)
      step(1'b1, 5'd20, pat(20, 9), 5'd20, 5'd21, "R5", "R8");
      step(1'b0, '0,    '0,         5'd20, 5'd20, "R2", "R2");
      step(1'b1, 5'd21, pat(21, 9), 5'd20, 5'd21, "R8", "R5");

      // R1 again: reset mid-run clears everything
      do_reset();
      for (int i = 0; i < NR; i++) step(1'b0, '0, '0, AW'(i), AW'(i), "R1", "R1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule